// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the slave-side command processor of a serial NOR flash, working one byte at a time. A host-facing transfer port presents one received byte per transfer while chip select is low. Each transfer yields exactly one response byte a fixed number of cycles later. The engine decodes the first byte of a selection as an opcode. It then gathers address, data or dummy bytes into a small internal buffer. Once enough bytes are in, it streams bytes from the array, passes program bytes to the array, or plays back the contents of a register.

The engine holds all volatile control state of the device: the write-enable and reset-enable latches, the 4-byte addressing flag, the extended address byte, the volatile configuration byte and the status protect bits. The storage array sits outside the block behind a plain read/write request port with one cycle of read latency. Releasing chip select always ends the current command.

Top module: `snor_cmd_engine`

## Requirements
- R1: Every transfer made while chip select is low produces `resp_valid` exactly three clock cycles later. The response byte is 0x00 for the opcode byte, for collected address, dummy and data bytes, and for page-program data bytes.
- R2: Opcode 0x05 returns the status byte with bit 0 at 0, bit 1 equal to the write-enable latch, and bits 7:2 equal to the protect bits. The same byte repeats on every further transfer while chip select stays low.
- R3: Opcode 0x06 sets the write-enable latch and 0x04 clears it. A page-program byte (opcode 0x02, then address, then data) reaches the array through `mem_we` only while the latch is set.
- R4: Opcode 0x03 takes the address most significant byte first and returns array bytes from consecutive addresses. In 3-byte mode the address is three bytes and the extended address byte supplies address bits 31:24. The assembled address is cut to ADDR_W bits.
- R5: During a memory read and during page program, the address advances by one after each byte and wraps from 2^ADDR_W-1 to 0.
- R6: Opcode 0xB7 selects 4-byte addressing and 0xE9 returns to 3-byte addressing. Opcode 0x70 returns a flag byte with bit 7 set and bit 0 equal to the 4-byte flag, repeated while chip select stays low.
- R7: Opcode 0x0B behaves like 0x03 but expects a number of dummy bytes after the address equal to bits 7:4 of the volatile configuration byte. Dummy bytes cause no array access. Opcode 0x85 reads the volatile configuration byte. Opcode 0x81 writes it, only while write enable is set.
- R8: Opcode 0xC8 reads the extended address byte. Opcode 0xC5 writes it, only while write enable is set.
- R9: Opcode 0x9F returns six identity bytes, taken most significant first from DEV_ID. Bytes beyond ID_BYTES read as 0x00. The engine is then idle, so the next byte is taken as an opcode.
- R10: Opcode 0x99 resets the volatile state only when the opcode decoded just before it was 0x66; any other opcode clears that enable. The reset clears write enable, 4-byte mode, extended address and protect bits, and reloads the configuration byte with VCFG_INIT.
- R11: If a command needs more bytes than the 16-byte buffer holds, the first byte that does not fit aborts the command. That byte is not decoded, and the next byte is decoded as an opcode.
- R12: Chip select high forces the engine idle. Opcode 0x01, accepted only with write enable set, collects one or two bytes and completes at the second byte or at chip select release. Byte 0 bits 7:2 become the protect bits, byte 1 becomes the configuration byte, and write enable is cleared.
- R13: While `rst` is high, `resp_valid`, `mem_re` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| xfer_valid | input | 1 | One received byte is presented this cycle |
| xfer_rx | input | 8 | Received byte |
| resp_valid | output | 1 | Response byte valid, three cycles after its transfer |
| resp_byte | output | 8 | Response byte |
| mem_re | output | 1 | Array read request |
| mem_we | output | 1 | Array program request |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Program data |
| mem_rdata | input | 8 | Array read data, one cycle after `mem_re` |

## Verification
Reads are swept over several start addresses, including one near the top of the 24-bit range, and with every extended address value that matters. This separates correct byte ordering from a merely plausible address. Fast reads are swept over dummy counts 0 to 3, and over 12 and 13 with 4-byte addressing. These sweeps show that the byte count follows the configuration field and that the buffer limit falls exactly between the last count that fits and the first that does not. Write-gated commands, the two-step reset and the variable-length status write are each tried with the enabling step present and absent, so a gate that is missing or always closed shows up at the ports.

// File: rtl/snor_pkg.sv
package snor_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_COLLECT_VAR,
    ST_PROGRAM,
    ST_MEMREAD,
    ST_READOUT
  } eng_state_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_RDFS  = 8'h70;
  localparam logic [7:0] OP_RDID  = 8'h9F;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;
  localparam logic [7:0] OP_EN4B  = 8'hB7;
  localparam logic [7:0] OP_EX4B  = 8'hE9;
  localparam logic [7:0] OP_RDEXT = 8'hC8;
  localparam logic [7:0] OP_WREXT = 8'hC5;
  localparam logic [7:0] OP_RDCFG = 8'h85;
  localparam logic [7:0] OP_WRCFG = 8'h81;

  localparam int ID_LEN = 6;

endpackage

// File: rtl/snor_addr_build.sv
module snor_addr_build #(
  parameter int ADDR_W = 26
) (
  input  logic [31:0]       lanes,
  input  logic              four_b,
  input  logic [7:0]        ext_addr,
  output logic [ADDR_W-1:0] addr
);
  logic [31:0] wide;

  // lanes holds the first four collected bytes, first byte in the top lane
  always_comb begin
    if (four_b) wide = lanes;
    else        wide = {ext_addr, lanes[31:8]};
  end

  assign addr = wide[ADDR_W-1:0];
endmodule

// File: rtl/snor_resp_pipe.sv
module snor_resp_pipe (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_from_mem,
  input  logic [7:0] in_byte,
  input  logic [7:0] mem_rdata,
  output logic       resp_valid,
  output logic [7:0] resp_byte
);
  logic       s1_v, s2_v, s1_m, s2_m;
  logic [7:0] s1_b, s2_b;

  // stage 1 lines up with the array request, stage 2 with the array data
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_m <= 1'b0; s1_b <= '0;
      s2_v <= 1'b0; s2_m <= 1'b0; s2_b <= '0;
      resp_valid <= 1'b0;
      resp_byte  <= '0;
    end else begin
      s1_v <= in_valid; s1_m <= in_from_mem; s1_b <= in_byte;
      s2_v <= s1_v;     s2_m <= s1_m;        s2_b <= s1_b;
      resp_valid <= s2_v;
      resp_byte  <= s2_m ? mem_rdata : s2_b;
    end
  end
endmodule

// File: rtl/snor_cmd_engine.sv
module snor_cmd_engine
  import snor_pkg::*;
#(
  parameter int          ADDR_W    = 26,
  parameter int          BUF_DEPTH = 16,
  parameter int          ID_BYTES  = 3,
  parameter logic [47:0] DEV_ID    = 48'hC2_20_19_AA_BB_CC,
  parameter logic [7:0]  VCFG_INIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              xfer_valid,
  input  logic [7:0]        xfer_rx,
  output logic              resp_valid,
  output logic [7:0]        resp_byte,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W  = $clog2(BUF_DEPTH);
  localparam int NEED_W = CNT_W + 2;

  eng_state_t        state;
  logic [7:0]        cmd;
  logic [NEED_W-1:0] need;
  logic [CNT_W-1:0]  len;
  logic [IDX_W-1:0]  pos, rlen;
  logic              loop_rd;
  logic [7:0]        buf_q [BUF_DEPTH];
  logic              wel, rsten, four_b;
  logic [7:0]        ext_addr, vcfg;
  logic [5:0]        prot;
  logic [ADDR_W-1:0] cur_addr;

  logic [7:0]        lane [4];
  logic [ADDR_W-1:0] addr_c;
  logic [2:0]        alen;
  logic              go, last_byte;
  logic              r_mem;
  logic [7:0]        r_byte;

  assign go        = xfer_valid & ~cs_n;
  assign alen      = four_b ? 3'd4 : 3'd3;
  assign last_byte = (NEED_W'(len) + NEED_W'(1)) == need;

  // the byte arriving now stands in for the buffer slot it will fill
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = (len == CNT_W'(g)) ? xfer_rx : buf_q[g];
  end

  snor_addr_build #(.ADDR_W(ADDR_W)) u_addr (
    .lanes    ({lane[0], lane[1], lane[2], lane[3]}),
    .four_b   (four_b),
    .ext_addr (ext_addr),
    .addr     (addr_c)
  );

  always_comb begin
    r_mem  = (state == ST_MEMREAD);
    r_byte = (state == ST_READOUT) ? buf_q[pos] : 8'h00;
  end

  snor_resp_pipe u_resp (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (go),
    .in_from_mem (r_mem),
    .in_byte     (r_byte),
    .mem_rdata   (mem_rdata),
    .resp_valid  (resp_valid),
    .resp_byte   (resp_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cmd      <= 8'h00;
      need     <= '0;
      len      <= '0;
      pos      <= '0;
      rlen     <= '0;
      loop_rd  <= 1'b0;
      wel      <= 1'b0;
      rsten    <= 1'b0;
      four_b   <= 1'b0;
      ext_addr <= 8'h00;
      vcfg     <= VCFG_INIT;
      prot     <= '0;
      cur_addr <= '0;
      mem_re   <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_wdata <= 8'h00;
      for (int i = 0; i < BUF_DEPTH; i++) buf_q[i] <= 8'h00;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      if (cs_n) begin
        // deselect: finish a pending variable-length write, then idle
        if (state == ST_COLLECT_VAR) begin
          if (len != '0) prot <= buf_q[0][7:2];
          wel <= 1'b0;
        end
        state   <= ST_IDLE;
        loop_rd <= 1'b0;
      end else if (xfer_valid) begin
        case (state)
          ST_IDLE: begin
            cmd <= xfer_rx;
            len <= '0;
            pos <= '0;
            if (xfer_rx != OP_RST) rsten <= 1'b0;
            case (xfer_rx)
              OP_WREN:  wel <= 1'b1;
              OP_WRDI:  wel <= 1'b0;
              OP_EN4B:  four_b <= 1'b1;
              OP_EX4B:  four_b <= 1'b0;
              OP_RSTEN: rsten <= 1'b1;
              OP_RST: begin
                if (rsten) begin
                  wel      <= 1'b0;
                  four_b   <= 1'b0;
                  ext_addr <= 8'h00;
                  vcfg     <= VCFG_INIT;
                  prot     <= '0;
                end
                rsten <= 1'b0;
              end
              OP_RDSR: begin
                buf_q[0] <= {prot, wel, 1'b0};
                rlen <= IDX_W'(1); loop_rd <= 1'b1; state <= ST_READOUT;
              end
              OP_RDFS: begin
                buf_q[0] <= {1'b1, 6'b0, four_b};
                rlen <= IDX_W'(1); loop_rd <= 1'b1; state <= ST_READOUT;
              end
              OP_RDCFG: begin
                buf_q[0] <= vcfg;
                rlen <= IDX_W'(1); loop_rd <= 1'b0; state <= ST_READOUT;
              end
              OP_RDEXT: begin
                buf_q[0] <= ext_addr;
                rlen <= IDX_W'(1); loop_rd <= 1'b0; state <= ST_READOUT;
              end
              OP_RDID: begin
                for (int i = 0; i < ID_LEN; i++)
                  buf_q[i] <= (i < ID_BYTES) ? DEV_ID[47-8*i -: 8] : 8'h00;
                rlen <= IDX_W'(ID_LEN); loop_rd <= 1'b0; state <= ST_READOUT;
              end
              OP_READ, OP_PROG: begin
                need  <= NEED_W'(alen);
                state <= ST_COLLECT;
              end
              OP_FAST: begin
                need  <= NEED_W'(alen) + NEED_W'(vcfg[7:4]);
                state <= ST_COLLECT;
              end
              OP_WREXT, OP_WRCFG: begin
                if (wel) begin
                  need  <= NEED_W'(1);
                  state <= ST_COLLECT;
                end
              end
              OP_WRSR: begin
                if (wel) begin
                  need  <= NEED_W'(2);
                  state <= ST_COLLECT_VAR;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
          ST_COLLECT, ST_COLLECT_VAR: begin
            if (len == CNT_W'(BUF_DEPTH)) begin
              state <= ST_IDLE;
            end else begin
              buf_q[len[IDX_W-1:0]] <= xfer_rx;
              len <= len + CNT_W'(1);
              if (last_byte) begin
                state <= ST_IDLE;
                case (cmd)
                  OP_READ, OP_FAST: begin
                    cur_addr <= addr_c;
                    state    <= ST_MEMREAD;
                  end
                  OP_PROG: begin
                    cur_addr <= addr_c;
                    state    <= ST_PROGRAM;
                  end
                  OP_WREXT: ext_addr <= xfer_rx;
                  OP_WRCFG: vcfg <= xfer_rx;
                  OP_WRSR: begin
                    prot <= buf_q[0][7:2];
                    vcfg <= xfer_rx;
                    wel  <= 1'b0;
                  end
                  default: state <= ST_IDLE;
                endcase
              end
            end
          end
          ST_PROGRAM: begin
            if (wel) begin
              mem_we    <= 1'b1;
              mem_addr  <= cur_addr;
              mem_wdata <= xfer_rx;
            end
            cur_addr <= cur_addr + ADDR_W'(1);
          end
          ST_MEMREAD: begin
            mem_re   <= 1'b1;
            mem_addr <= cur_addr;
            cur_addr <= cur_addr + ADDR_W'(1);
          end
          ST_READOUT: begin
            if (pos == rlen - IDX_W'(1)) begin
              pos <= '0;
              if (!loop_rd) state <= ST_IDLE;
            end else begin
              pos <= pos + IDX_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !cs_n) |-> ##3 resp_valid); // R1

  AST_PROGRAM_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wel)); // R3

  AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    len <= CNT_W'(BUF_DEPTH)); // R11

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (state == ST_IDLE)); // R12

endmodule

// File: tb/snor_cmd_engine_tb.sv
module snor_cmd_engine_tb;
  localparam logic [31:0] MASK = 32'h03FF_FFFF;

  logic        clk = 1'b0;
  logic        rst, cs_n, xfer_valid;
  logic [7:0]  xfer_rx;
  logic        resp_valid, mem_re, mem_we;
  logic [7:0]  resp_byte, mem_wdata, mem_rdata;
  logic [25:0] mem_addr;

  int checks = 0;
  int errs   = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [31:0] last_ra, last_wa;
  logic [7:0]  bmem [256];
  logic [7:0]  rb;
  logic        rv;
  logic [7:0]  rdbuf [8];

  always #5 clk = ~clk;

  snor_cmd_engine u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .xfer_valid(xfer_valid), .xfer_rx(xfer_rx),
    .resp_valid(resp_valid), .resp_byte(resp_byte), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) bmem[i] <= pat(i[7:0]);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) begin
        bmem[mem_addr[7:0]] <= mem_wdata;
        last_wa <= {6'b0, mem_addr};
        wr_cnt  <= wr_cnt + 1;
      end
      if (mem_re) begin
        mem_rdata <= bmem[mem_addr[7:0]];
        last_ra   <= {6'b0, mem_addr};
        rd_cnt    <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk); xfer_valid = 1'b1; xfer_rx = b;
    @(posedge clk);
    @(negedge clk); xfer_valid = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rb = resp_byte; rv = resp_valid;
  endtask

  task automatic csl(); @(negedge clk); cs_n = 1'b0; endtask
  task automatic csh(); @(negedge clk); cs_n = 1'b1; @(negedge clk); @(negedge clk); endtask

  task automatic cmd1(input logic [7:0] op); csl(); xfer(op); csh(); endtask
  task automatic cmd2(input logic [7:0] op, input logic [7:0] d); csl(); xfer(op); xfer(d); csh(); endtask

  task automatic rd_reg(input logic [7:0] op, input int n, input logic [7:0] exp, input string tag);
    csl(); xfer(op);
    chk({tag, " opcode response"}, rb, 8'h00);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00);
      chk(tag, rb, exp);
    end
    csh();
  endtask

  task automatic do_read(input logic [7:0] op, input logic [31:0] a, input bit four,
                         input int nd, input int nb, input logic [31:0] base,
                         input bit use_pat, input string tag);
    int rc;
    logic [31:0] ea;
    csl(); xfer(op);
    chk("R1 opcode response zero and valid", {rv, rb}, 9'h100);
    if (four) xfer(a[31:24]);
    xfer(a[23:16]); xfer(a[15:8]); xfer(a[7:0]);
    chk("R1 address byte response zero", rb, 8'h00);
    rc = rd_cnt;
    for (int k = 0; k < nd; k++) begin
      xfer(8'h00);
      chk("R7 dummy byte response zero", rb, 8'h00);
    end
    chk("R7 no array access during address and dummy", rd_cnt, rc);
    for (int k = 0; k < nb; k++) begin
      xfer(8'h00);
      ea = (base + k) & MASK;
      chk({tag, " address"}, last_ra, ea);
      if (use_pat) chk({tag, " data"}, rb, pat(ea[7:0]));
      rdbuf[k] = rb;
    end
    csh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; xfer_valid = 1'b0; xfer_rx = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R13 reset outputs quiet", {resp_valid, mem_re, mem_we}, 3'b000);
    rst = 1'b0;
    @(negedge clk);

    // R2 / R3 status and write enable latch
    rd_reg(8'h05, 3, 8'h00, "R2 status after reset");
    cmd1(8'h06);
    rd_reg(8'h05, 4, 8'h02, "R3 status with write enable repeats");
    cmd1(8'h04);
    rd_reg(8'h05, 1, 8'h00, "R3 write disable clears latch");

    // R4 read sweep in 3-byte mode
    begin
      logic [31:0] pts [4];
      pts[0] = 32'h000000; pts[1] = 32'h0000FE; pts[2] = 32'h123456; pts[3] = 32'hFFFFFE;
      for (int i = 0; i < 4; i++)
        do_read(8'h03, pts[i], 1'b0, 0, 4, pts[i], 1'b1, "R4 read sweep");
    end

    // R8 extended address
    cmd2(8'hC5, 8'h02);
    rd_reg(8'hC8, 1, 8'h00, "R8 ext write without enable ignored");
    cmd1(8'h06); cmd2(8'hC5, 8'h02);
    rd_reg(8'hC8, 1, 8'h02, "R8 ext write with enable");
    do_read(8'h03, 32'h000010, 1'b0, 0, 1, 32'h2000010, 1'b1, "R4 ext supplies high bits");
    cmd1(8'h06); cmd2(8'hC5, 8'hFF);
    do_read(8'h03, 32'h000010, 1'b0, 0, 1, 32'h3000010, 1'b1, "R4 address masked");
    cmd1(8'h06); cmd2(8'hC5, 8'h00);

    // R6 4-byte mode, R5 read wrap
    rd_reg(8'h70, 2, 8'h80, "R6 flag status 3-byte");
    cmd1(8'hB7);
    rd_reg(8'h70, 2, 8'h81, "R6 flag status 4-byte");
    do_read(8'h03, 32'h03FFFFFF, 1'b1, 0, 2, 32'h03FFFFFF, 1'b1, "R5 read wrap");
    do_read(8'h03, 32'hFF000010, 1'b1, 0, 1, 32'h03000010, 1'b1, "R6 4-byte masked");
    cmd1(8'hE9);
    rd_reg(8'h70, 1, 8'h80, "R6 exit 4-byte");

    // R7 fast read dummy sweep
    for (int d = 0; d < 4; d++) begin
      cmd1(8'h06); cmd2(8'h81, {d[3:0], 4'h0});
      rd_reg(8'h85, 1, {d[3:0], 4'h0}, "R7 configuration readback");
      do_read(8'h0B, 32'h40 + d, 1'b0, d, 2, 32'h40 + d, 1'b1, "R7 fast read");
    end
    cmd1(8'h04); cmd2(8'h81, 8'h70);
    rd_reg(8'h85, 1, 8'h30, "R7 configuration write without enable ignored");

    // R3 program gating, R5 program wrap
    begin
      int wc;
      wc = wr_cnt;
      csl(); xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h20); xfer(8'h55); csh();
      chk("R3 program without enable blocked", wr_cnt, wc);
      do_read(8'h03, 32'h20, 1'b0, 0, 1, 32'h20, 1'b1, "R3 blocked program readback");
      cmd1(8'h06);
      csl(); xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h30);
      xfer(8'hA1); chk("R1 program byte response zero", rb, 8'h00);
      xfer(8'hA2); csh();
      chk("R3 program address", last_wa, 32'h31);
      do_read(8'h03, 32'h30, 1'b0, 0, 2, 32'h30, 1'b0, "R3 program readback");
      chk("R3 programmed byte 0", rdbuf[0], 8'hA1);
      chk("R3 programmed byte 1", rdbuf[1], 8'hA2);
      cmd1(8'hB7);
      csl(); xfer(8'h02); xfer(8'h03); xfer(8'hFF); xfer(8'hFF); xfer(8'hFF);
      xfer(8'h11); xfer(8'h22); csh();
      chk("R5 program wraps to zero", last_wa, 32'h0);
      do_read(8'h03, 32'h03FFFFFF, 1'b1, 0, 2, 32'h03FFFFFF, 1'b0, "R5 program wrap readback");
      chk("R5 wrap byte top", rdbuf[0], 8'h11);
      chk("R5 wrap byte zero", rdbuf[1], 8'h22);
      cmd1(8'hE9);
    end

    // R9 identification
    begin
      logic [7:0] idx [6];
      idx[0] = 8'hC2; idx[1] = 8'h20; idx[2] = 8'h19; idx[3] = 8'h00; idx[4] = 8'h00; idx[5] = 8'h00;
      csl(); xfer(8'h9F);
      for (int k = 0; k < 6; k++) begin
        xfer(8'h00);
        chk("R9 id byte", rb, idx[k]);
      end
      xfer(8'h05);
      chk("R9 idle after id, byte taken as opcode", rb, 8'h00);
      xfer(8'h00);
      chk("R9 following status readout", rb, 8'h02);
      csh();
    end

    // R10 two-step reset
    cmd1(8'h06); cmd2(8'h01, 8'h08);
    rd_reg(8'h05, 1, 8'h08, "R12 single byte status write on release");
    cmd1(8'h06); cmd1(8'hB7); cmd2(8'hC5, 8'h01);
    cmd1(8'h06); cmd2(8'h81, 8'h30);
    cmd1(8'h66); cmd1(8'h05); cmd1(8'h99);
    rd_reg(8'h70, 1, 8'h81, "R10 reset blocked by intervening opcode");
    rd_reg(8'hC8, 1, 8'h01, "R10 ext kept without enable");
    cmd1(8'h66); cmd1(8'h99);
    rd_reg(8'h70, 1, 8'h80, "R10 reset clears 4-byte");
    rd_reg(8'hC8, 1, 8'h00, "R10 reset clears ext");
    rd_reg(8'h85, 1, 8'h80, "R10 reset reloads configuration");
    rd_reg(8'h05, 1, 8'h00, "R10 reset clears status");

    // R11 buffer overflow
    begin
      int rc;
      cmd1(8'hB7); cmd1(8'h06); cmd2(8'h81, 8'hD0);
      rc = rd_cnt;
      csl(); xfer(8'h0B);
      for (int k = 0; k < 16; k++) xfer(8'h00);
      xfer(8'h00);
      chk("R11 overflow byte response zero", rb, 8'h00);
      xfer(8'h05);
      chk("R11 opcode after abort", rb, 8'h00);
      xfer(8'h00);
      chk("R11 status decoded after abort", rb, 8'h02);
      csh();
      chk("R11 no array access on abort", rd_cnt, rc);
      cmd1(8'h06); cmd2(8'h81, 8'hC0);
      do_read(8'h0B, 32'h00000005, 1'b1, 12, 2, 32'h5, 1'b1, "R11 sixteen bytes fit");
      cmd1(8'hE9);
    end

    // R12 variable length status write and deselect
    cmd1(8'h06);
    csl(); xfer(8'h01); xfer(8'hA4); xfer(8'h50); csh();
    rd_reg(8'h05, 1, 8'hA4, "R12 two byte status write");
    rd_reg(8'h85, 1, 8'h50, "R12 second byte sets configuration");
    cmd2(8'h01, 8'h00);
    rd_reg(8'h05, 1, 8'hA4, "R12 status write without enable ignored");
    csl(); xfer(8'h03); xfer(8'h12); csh();
    rd_reg(8'h05, 2, 8'hA4, "R12 deselect aborts collection");

    finish_run();
  end
endmodule